// File: doc/BRIEF.md
# Power-Sequencing Timing Alert Monitor

This block sits beside a three-channel shunt and bus voltage monitor. That monitor reports its conversion results in a fixed round-robin order: channel 1 shunt, channel 1 bus, channel 2 shunt, channel 2 bus, channel 3 shunt, channel 3 bus. The block uses these results to check that a second supply rail comes up soon enough after a first one. It is a one-shot check. An arm pulse starts it, and that pulse is issued at power-up or when software sets the reset bit of the configuration register. Once armed, the block watches only the channel-1 bus result until that result reaches a threshold code. It then watches the channel-2 bus result.

The window is counted in complete measurement rounds, not in clock ticks. The channel-3 bus result closes each round. If channel 2 has not reached the threshold by the close of the fourth round after the channel-1 detection, the active-low alert output is driven low and held there. Any configuration write made while the check is still running turns the function off until the next arm pulse. In that case the alert stays high and a status flag reports the disabled state.

Top module: `seq_alert_mon`

## Requirements
- R1: After `rst` the outputs are `alert_n`=1, `done`=0, `disabled`=0. Until the first `arm_pulse`, no result and no `cfg_wr` changes them.
- R2: `arm_pulse` restarts the check from any state and clears the round count. The outputs become `alert_n`=1, `done`=0, `disabled`=0, even when `cfg_wr` is high in the same cycle.
- R3: While waiting for rail 1, only a valid result with `res_chan`=0 and `res_is_bus`=1 counts. It detects when `res_code` >= `TH_CODE`, and a code equal to `TH_CODE` detects. Shunt results (`res_is_bus`=0) and other channels are ignored whatever their code.
- R4: After rail 1 is detected, a valid result with `res_chan`=1 and `res_is_bus`=1 and `res_code` >= `TH_CODE` sets `done`=1 with `alert_n`=1. Both hold until the next `arm_pulse`.
- R5: After rail 1 is detected, each valid result with `res_chan`=2 and `res_is_bus`=1 ends one round. When round `NUM_ROUNDS` (default 4) ends without a rail-2 detection, `alert_n` goes to 0. A rail-2 detection inside the last round still gives `done`=1.
- R6: Once `alert_n` is 0 it stays 0 until `arm_pulse`, including after a later rail-2 result at or above the threshold.
- R7: A `cfg_wr` while waiting for rail 1 or rail 2 sets `disabled`=1. After that, `alert_n` stays 1 and `done` stays 0 whatever results follow, until `arm_pulse`.
- R8: A `cfg_wr` after the check has finished (`done`=1 or `alert_n`=0) has no effect on the outputs.
- R9: The outputs are registered. They change on the first rising clock edge that samples the causing input, and they do not change before that edge.
- R10: A rail-2 result with `res_code` = `TH_CODE`-1 does not detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, puts the block in idle |
| arm_pulse | input | 1 | Power-up or software-reset pulse that starts the check |
| cfg_wr | input | 1 | Strobe for a configuration register write |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_chan | input | CHAN_W | Channel of the result, 0 to 2 for channels 1 to 3 |
| res_is_bus | input | 1 | 1 = bus-voltage result, 0 = shunt result |
| res_code | input | CODE_W | Result code |
| alert_n | output | 1 | Active-low sequencing alert, latched |
| done | output | 1 | Rail 2 was seen inside the window |
| disabled | output | 1 | The check was turned off by a configuration write |

## Verification
The bench drives full six-result rounds with different code patterns and compares against its own model on every clock. A rail-1 code of `TH_CODE`-1 followed by `TH_CODE` tests whether an equal code detects. High codes on shunt results and on other channels while waiting for rail 1 show which tags the comparison honours. Rail 2 is tried in three cases: arriving in the first round, arriving in the fourth round, and never arriving. These separate an off-by-one round count from the correct window. Configuration writes are placed in both waiting states, in the two finished states and in the same cycle as an arm pulse, which exercises the disarm rule and its priority.

// File: rtl/seq_alert_pkg.sv
package seq_alert_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT1 = 3'd1,
    ST_WAIT2 = 3'd2,
    ST_DONE  = 3'd3,
    ST_ALERT = 3'd4,
    ST_OFF   = 3'd5
  } mon_state_t;

  localparam int RAIL1_IDX = 0;
  localparam int RAIL2_IDX = 1;
endpackage

// File: rtl/seq_tag_decode.sv
module seq_tag_decode #(
  parameter int NUM_CH = 3,
  parameter int CHAN_W = 2
) (
  input  logic              valid,
  input  logic [CHAN_W-1:0] chan,
  input  logic              is_bus,
  output logic [NUM_CH-1:0] bus_hit
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign bus_hit[i] = valid && is_bus && (chan == CHAN_W'(i));
  end
endmodule

// File: rtl/seq_level_cmp.sv
module seq_level_cmp #(
  parameter int CODE_W  = 13,
  parameter int TH_CODE = 150
) (
  input  logic [CODE_W-1:0] code,
  output logic              at_level
);
  localparam logic [CODE_W-1:0] TH = CODE_W'(TH_CODE);
  assign at_level = (code >= TH);
endmodule

// File: rtl/seq_round_cnt.sv
module seq_round_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = inc && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r5_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && (cnt_q != LAST)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r2_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/seq_alert_mon.sv
module seq_alert_mon
  import seq_alert_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int CHAN_W     = 2,
  parameter int CODE_W     = 13,
  parameter int TH_CODE    = 150,
  parameter int NUM_ROUNDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_pulse,
  input  logic              cfg_wr,
  input  logic              res_valid,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic              res_is_bus,
  input  logic [CODE_W-1:0] res_code,
  output logic              alert_n,
  output logic              done,
  output logic              disabled
);
  localparam int CLOSE_IDX = NUM_CH - 1;

  mon_state_t       state_q, state_d;
  logic [NUM_CH-1:0] bus_hit;
  logic             at_level;
  logic             rail1_seen, rail2_seen, round_end, expire, cnt_clr;

  seq_tag_decode #(.NUM_CH(NUM_CH), .CHAN_W(CHAN_W)) u_dec (
    .valid(res_valid), .chan(res_chan), .is_bus(res_is_bus), .bus_hit(bus_hit)
  );

  seq_level_cmp #(.CODE_W(CODE_W), .TH_CODE(TH_CODE)) u_cmp (
    .code(res_code), .at_level(at_level)
  );

  assign rail1_seen = bus_hit[RAIL1_IDX] && at_level;
  assign rail2_seen = bus_hit[RAIL2_IDX] && at_level;
  assign round_end  = (state_q == ST_WAIT2) && bus_hit[CLOSE_IDX];
  assign cnt_clr    = arm_pulse || ((state_q == ST_WAIT1) && rail1_seen);

  seq_round_cnt #(.LIMIT(NUM_ROUNDS)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(round_end), .expire(expire)
  );

  always_comb begin
    state_d = state_q;
    if (arm_pulse) begin
      state_d = ST_WAIT1;
    end else begin
      unique case (state_q)
        ST_WAIT1: begin
          if (cfg_wr)          state_d = ST_OFF;
          else if (rail1_seen) state_d = ST_WAIT2;
        end
        ST_WAIT2: begin
          if (cfg_wr)          state_d = ST_OFF;
          else if (rail2_seen) state_d = ST_DONE;
          else if (expire)     state_d = ST_ALERT;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      alert_n  <= 1'b1;
      done     <= 1'b0;
      disabled <= 1'b0;
    end else begin
      state_q  <= state_d;
      alert_n  <= (state_d != ST_ALERT);
      done     <= (state_d == ST_DONE);
      disabled <= (state_d == ST_OFF);
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && !arm_pulse) |=> (alert_n && !done && !disabled));
  a_r2_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm_pulse |=> (alert_n && !done && !disabled));
  a_r4_done_held: assert property (@(posedge clk) disable iff (rst)
    (done && !arm_pulse) |=> (done && alert_n));
  a_r5_alert_on_close: assert property (@(posedge clk) disable iff (rst)
    $fell(alert_n) |-> $past(bus_hit[CLOSE_IDX]));
  a_r6_alert_held: assert property (@(posedge clk) disable iff (rst)
    (!alert_n && !arm_pulse) |=> !alert_n);
  a_r7_cfg_disables: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !arm_pulse && ((state_q == ST_WAIT1) || (state_q == ST_WAIT2)))
      |=> (disabled && alert_n));
endmodule

// File: tb/seq_alert_mon_tb.sv
module seq_alert_mon_tb;
  localparam int CODE_W = 13;
  localparam int TH     = 150;
  localparam int ROUNDS = 4;

  logic clk = 1'b0;
  logic rst, arm_pulse, cfg_wr, res_valid, res_is_bus;
  logic [1:0] res_chan;
  logic [CODE_W-1:0] res_code;
  logic alert_n, done, disabled;

  int checks = 0;
  int errors = 0;
  int mstate = 0;  // 0 idle 1 wait1 2 wait2 3 done 4 alert 5 off
  int mrounds = 0;

  always #2.5 clk = ~clk;

  seq_alert_mon u_dut (
    .clk(clk), .rst(rst), .arm_pulse(arm_pulse), .cfg_wr(cfg_wr),
    .res_valid(res_valid), .res_chan(res_chan), .res_is_bus(res_is_bus),
    .res_code(res_code), .alert_n(alert_n), .done(done), .disabled(disabled)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, updated from inputs sampled at the edge
  always @(posedge clk) begin
    bit hit;
    hit = res_valid && res_is_bus;
    if (rst) begin
      mstate = 0; mrounds = 0;
    end else if (arm_pulse) begin
      mstate = 1; mrounds = 0;
    end else if (mstate == 1) begin
      if (cfg_wr) mstate = 5;
      else if (hit && res_chan == 0 && res_code >= TH) begin mstate = 2; mrounds = 0; end
    end else if (mstate == 2) begin
      if (cfg_wr) mstate = 5;
      else if (hit && res_chan == 1 && res_code >= TH) mstate = 3;
      else if (hit && res_chan == 2) begin
        mrounds++;
        if (mrounds == ROUNDS) mstate = 4;
      end
    end
  end

  always @(negedge clk) begin
    if (rst === 1'b0) begin
      chk("R9 model alert_n", alert_n, mstate != 4);
      chk("R9 model done", done, mstate == 3);
      chk("R9 model disabled", disabled, mstate == 5);
    end
  end

  task automatic idle_in();
    arm_pulse = 0; cfg_wr = 0; res_valid = 0; res_chan = 0; res_is_bus = 0; res_code = 0;
  endtask

  task automatic send(int ch, bit bus, int code);
    res_valid = 1; res_chan = 2'(ch); res_is_bus = bus; res_code = CODE_W'(code);
    @(negedge clk);
    idle_in();
  endtask

  task automatic round(int c1, int c2, int c3);
    send(0, 0, 4000); send(0, 1, c1);
    send(1, 0, 4000); send(1, 1, c2);
    send(2, 0, 4000); send(2, 1, c3);
  endtask

  task automatic arm(bit with_cfg);
    arm_pulse = 1; cfg_wr = with_cfg;
    @(negedge clk);
    idle_in();
  endtask

  task automatic cfg();
    cfg_wr = 1;
    @(negedge clk);
    idle_in();
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_in(); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 alert_n", alert_n, 1); chk("R1 done", done, 0); chk("R1 disabled", disabled, 0);
    round(TH, TH, TH); cfg();
    chk("R1 idle alert_n", alert_n, 1); chk("R1 idle done", done, 0); chk("R1 idle disabled", disabled, 0);

    // R3: only channel-1 bus counts, threshold equality
    arm(0);
    round(TH - 1, TH, TH);
    chk("R3 other tags ignored", done, 0);
    send(0, 0, TH); send(1, 1, TH);
    chk("R3 shunt ignored", done, 0);
    send(0, 1, TH); send(1, 1, TH);
    chk("R3 equal detects / R4 done", done, 1);
    chk("R4 alert_n high", alert_n, 1);
    cfg();
    chk("R8 cfg after done", done, 1); chk("R8 disabled stays 0", disabled, 0);

    // R5/R10: window expiry
    arm(0);
    chk("R2 done cleared", done, 0);
    round(TH, TH - 1, 0); round(0, TH - 1, 0); round(0, 0, 0);
    chk("R10 below threshold", done, 0);
    send(0, 0, 0); send(0, 1, 0); send(1, 0, 0); send(1, 1, 0); send(2, 0, 0);
    chk("R5 alert not yet", alert_n, 1);
    send(2, 1, 0);
    chk("R5 alert on 4th round end", alert_n, 0);
    round(TH, TH, TH);
    chk("R6 alert held", alert_n, 0); chk("R6 no done", done, 0);
    cfg();
    chk("R8 cfg after alert", alert_n, 0); chk("R8 disabled 0", disabled, 0);

    // R7: disable while waiting rail 2
    arm(0);
    chk("R2 alert cleared", alert_n, 1);
    round(TH, 0, 0);
    cfg_wr = 1;
    #1 chk("R9 no early change", disabled, 0);
    @(negedge clk); idle_in();
    chk("R7 disabled", disabled, 1);
    for (int i = 0; i < 5; i++) round(TH, 0, 0);
    round(TH, TH, TH);
    chk("R7 alert stays high", alert_n, 1); chk("R7 no done", done, 0);

    // R2 priority, R7 in wait1
    arm(1);
    chk("R2 arm beats cfg", disabled, 0);
    cfg();
    chk("R7 disabled in wait1", disabled, 1);

    // R5 last-round boundary
    arm(0);
    round(TH, 0, 0); round(0, 0, 0); round(0, 0, 0);
    round(0, TH, 0);
    chk("R5 late rail2 done", done, 1); chk("R5 no alert", alert_n, 1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule